// File: doc/BRIEF.md
# DMA Channel Start-Source Selector

This block is the request front end of one DMA channel. A 5-bit select code picks what starts the channel. The choices are a software trigger bit, the channel's private external request line, or one of sixteen peripheral request lines that every channel can see. The block turns the chosen source into a one-clock start pulse for the transfer engine. It also drives a continue level that the engine samples at each transfer gap.

Block and burst transfers start on an edge of the source. Demand transfers follow the source level: the engine keeps going while the level is active and pauses at the next gap once it drops. Moving the select code onto a line that is already active counts as an edge. The software trigger bit lives in the block. A register write sets or clears it, and the block clears it itself when the transfer it started ends.

Top module: `dma_trig_sel`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, start, busy, st_bit and keep_going are all 0.
- R2: With sel = 0, a write of 1 to the software bit while idle gives start = 1 in the second cycle after the write cycle. Start lasts exactly one cycle, busy rises with it, and keep_going is 1 while the bit stays set.
- R3: xfer_done while busy drops busy on the next clock. If the transfer was started by software, the software bit clears on that same clock.
- R4: A write of 0 to the software bit during a software transfer drops keep_going. The next at_gap then ends the transfer without xfer_done.
- R5: sel = 0Eh in edge mode (demand = 0) starts on a rising edge of ext_req. Holding the line high gives no further start.
- R6: sel = 0Fh uses ext_req active-low. A falling edge starts a transfer and a rising edge does not.
- R7: sel = 10h + k follows only per_req[k]. Activity on the other lines gives no start.
- R8: In demand mode (demand = 1) an active selected level starts a transfer while idle. keep_going follows the level, and at_gap with the level inactive ends the transfer. A level that returns afterwards starts again.
- R9: Changing sel while the newly selected line is already active gives a start one cycle later, even when the line showed no edge.
- R10: Select codes 01h through 0Dh never produce a start, whatever the request lines and the software bit do.
- R11: While busy, edges on the selected line produce no start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 5 | Start-source select code |
| demand | input | 1 | 1 = demand (level) mode, 0 = block/burst (edge) mode |
| st_wr | input | 1 | Write strobe for the software trigger bit |
| st_wdata | input | 1 | Value written to the software trigger bit |
| ext_req | input | 1 | This channel's external request line |
| per_req | input | 16 | Shared peripheral request lines |
| xfer_done | input | 1 | Engine reports the transfer is complete |
| at_gap | input | 1 | Engine is at a transfer gap |
| st_bit | output | 1 | Current software trigger bit |
| busy | output | 1 | A transfer is in progress |
| start | output | 1 | One-cycle start pulse to the engine |
| keep_going | output | 1 | Engine may continue past the current gap |

## Verification
The bench moves the select code onto a peripheral line that is already high. A design that only compares the line with its own last value would miss that start. Active-low mode is driven with both edges, so an inverted polarity shows up as a start on the wrong edge. Edges are toggled during a busy transfer, which catches a detector that re-arms while the engine is running. The bench also walks all invalid codes with every line and the software bit high, since a loose decode would fire there. Demand mode is checked for a pause at the gap when the level drops, and for a fresh start when the level returns.

// File: rtl/dma_trig_sel.sv
module dma_trig_sel #(
  parameter int NPER = 16,
  parameter int SELW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] sel,
  input  logic            demand,
  input  logic            st_wr,
  input  logic            st_wdata,
  input  logic            ext_req,
  input  logic [NPER-1:0] per_req,
  input  logic            xfer_done,
  input  logic            at_gap,
  output logic            st_bit,
  output logic            busy,
  output logic            start,
  output logic            keep_going
);
  localparam logic [SELW-1:0] SEL_EXT_HI = SELW'(14);
  localparam logic [SELW-1:0] SEL_EXT_LO = SELW'(15);
  localparam int IDXW = SELW - 1;

  logic [IDXW-1:0] pidx;
  logic is_sw, is_ext, is_per, is_hw;
  logic line, act_q, edge_hit, hw_trig, start_c, end_c;
  logic [SELW-1:0] sel_q;

  assign pidx   = sel[IDXW-1:0];
  assign is_sw  = (sel == '0);
  assign is_ext = (sel == SEL_EXT_HI) || (sel == SEL_EXT_LO);
  assign is_per = sel[SELW-1] && (int'(pidx) < NPER);
  assign is_hw  = is_ext || is_per;

  always_comb begin
    line = 1'b0;
    if (is_ext)      line = ext_req ^ (sel == SEL_EXT_LO);
    else if (is_per) line = per_req[pidx];
  end

  assign edge_hit   = line && (!act_q || (sel != sel_q));
  assign hw_trig    = demand ? line : edge_hit;
  assign start_c    = !busy && (is_sw ? st_bit : (is_hw && hw_trig));
  assign keep_going = busy && (is_sw ? st_bit : (is_hw && (demand ? line : 1'b1)));
  assign end_c      = busy && (xfer_done || (at_gap && !keep_going));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sel_q  <= '0;
      st_bit <= 1'b0;
      busy   <= 1'b0;
      start  <= 1'b0;
    end else begin
      act_q <= line;
      sel_q <= sel;
      start <= start_c;
      if (st_wr)              st_bit <= st_wdata;
      else if (end_c && is_sw) st_bit <= 1'b0;
      if (start_c)    busy <= 1'b1;
      else if (end_c) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_trig_sel_chk.sv
module dma_trig_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] sel,
  input logic       start,
  input logic       busy,
  input logic       keep_going,
  input logic       xfer_done
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) start |=> !start); // R2
  AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n) start |-> busy); // R2
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (busy && xfer_done) |=> !busy); // R3
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) start |-> !$past(busy)); // R11
  AST_INVALID_SILENT: assert property (@(posedge clk) disable iff (!rst_n) start |-> !($past(sel) >= 5'd1 && $past(sel) <= 5'd13)); // R10
  AST_KEEP_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) keep_going |-> busy); // R8
endmodule

bind dma_trig_sel dma_trig_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .start(start),
  .busy(busy), .keep_going(keep_going), .xfer_done(xfer_done)
);

// File: tb/dma_trig_sel_bench.sv
module dma_trig_sel_bench;
  logic clk = 0, rst_n = 0;
  logic [4:0] sel = 0;
  logic demand = 0, st_wr = 0, st_wdata = 0, ext_req = 0, xfer_done = 0, at_gap = 0;
  logic [15:0] per_req = 0;
  logic st_bit, busy, start, keep_going;
  int total = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_trig_sel u_dma_trig_sel (
    .clk(clk), .rst_n(rst_n), .sel(sel), .demand(demand), .st_wr(st_wr),
    .st_wdata(st_wdata), .ext_req(ext_req), .per_req(per_req),
    .xfer_done(xfer_done), .at_gap(at_gap), .st_bit(st_bit), .busy(busy),
    .start(start), .keep_going(keep_going)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic sw_write(input logic v);
    st_wr = 1; st_wdata = v; tick; st_wr = 0;
  endtask

  task automatic done_pulse;
    xfer_done = 1; tick; xfer_done = 0;
  endtask

  task automatic t_reset;
    tick; tick;
    chk("R1 start in reset", start, 0); chk("R1 busy in reset", busy, 0);
    chk("R1 st_bit in reset", st_bit, 0); chk("R1 keep in reset", keep_going, 0);
    rst_n = 1; tick;
    chk("R1 start after", start, 0); chk("R1 busy after", busy, 0);
    chk("R1 st_bit after", st_bit, 0); chk("R1 keep after", keep_going, 0);
  endtask

  task automatic t_sw_start;
    sel = 0; tick;
    sw_write(1);
    chk("R2 no early start", start, 0);
    tick;
    chk("R2 start", start, 1); chk("R2 busy", busy, 1); chk("R2 keep", keep_going, 1);
    tick;
    chk("R2 one cycle", start, 0);
    done_pulse;
    chk("R3 busy cleared", busy, 0); chk("R3 st_bit cleared", st_bit, 0);
    tick;
    chk("R3 no restart", start, 0);
  endtask

  task automatic t_sw_stop;
    sw_write(1); tick;
    chk("R4 start", start, 1);
    sw_write(0);
    chk("R4 keep dropped", keep_going, 0); chk("R4 still busy", busy, 1);
    at_gap = 1; tick; at_gap = 0;
    chk("R4 stopped at gap", busy, 0);
    tick;
    chk("R4 no restart", start, 0);
  endtask

  task automatic t_ext_rise;
    sel = 5'h0E; tick; tick;
    ext_req = 1; tick;
    chk("R5 rising start", start, 1);
    done_pulse;
    for (int i = 0; i < 3; i++) begin
      tick;
      chk("R5 held high no start", start, 0); chk("R5 held high idle", busy, 0);
    end
  endtask

  task automatic t_ext_fall;
    sel = 5'h0F; tick; tick;
    chk("R6 no start on select", busy, 0);
    ext_req = 0; tick;
    chk("R6 falling start", start, 1);
    done_pulse;
    ext_req = 1;
    for (int i = 0; i < 3; i++) begin
      tick;
      chk("R6 rising no start", start, 0); chk("R6 rising idle", busy, 0);
    end
  endtask

  task automatic t_per;
    per_req = 0; sel = 5'h13; tick;
    ext_req = 0; tick;
    per_req = 16'hFFF7;
    for (int i = 0; i < 3; i++) begin
      tick;
      chk("R7 other lines ignored", start, 0);
    end
    per_req = 16'hFFFF; tick;
    chk("R7 line 3 start", start, 1);
    done_pulse;
  endtask

  task automatic t_sel_change;
    tick;
    chk("R9 idle before change", busy, 0);
    sel = 5'h15; tick;
    chk("R9 select change start", start, 1);
    done_pulse;
  endtask

  task automatic t_invalid;
    ext_req = 1;
    sw_write(1);
    for (int s = 1; s <= 13; s++) begin
      sel = 5'(s); tick;
      chk("R10 invalid no start", start, 0);
      tick;
      chk("R10 invalid no start", start, 0); chk("R10 invalid idle", busy, 0);
    end
    sw_write(0);
    per_req = 0; ext_req = 0; sel = 0; tick; tick;
  endtask

  task automatic t_demand;
    demand = 1; sel = 5'h1A; per_req = 0; tick; tick;
    per_req[10] = 1; tick;
    chk("R8 level start", start, 1); chk("R8 keep high", keep_going, 1);
    tick;
    chk("R8 single start", start, 0); chk("R8 busy held", busy, 1);
    per_req[10] = 0; tick;
    chk("R8 keep follows level", keep_going, 0); chk("R8 busy until gap", busy, 1);
    at_gap = 1; tick; at_gap = 0;
    chk("R8 paused at gap", busy, 0);
    per_req[10] = 1; tick;
    chk("R8 level restart", start, 1);
    xfer_done = 1; per_req = 0; tick; xfer_done = 0;
    tick;
    chk("R8 idle after done", busy, 0);
    demand = 0;
  endtask

  task automatic t_busy_ignore;
    sel = 5'h0E; ext_req = 0; tick; tick;
    ext_req = 1; tick;
    chk("R11 start", start, 1);
    for (int i = 0; i < 2; i++) begin
      ext_req = 0; tick; ext_req = 1; tick;
      chk("R11 edge while busy ignored", start, 0); chk("R11 still busy", busy, 1);
    end
    done_pulse;
    ext_req = 0; tick;
  endtask

  initial begin
    t_reset;
    t_sw_start;
    t_sw_stop;
    t_ext_rise;
    t_ext_fall;
    t_per;
    t_sel_change;
    t_invalid;
    t_demand;
    t_busy_ignore;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule